// File: doc/BRIEF.md
# Partial-Word Store Unit

This block carries out "store bytes" requests that write only the leading or only the trailing part of an aligned word in memory. Each request supplies a base address, the register value to store, a begin/end mode, a modify flag and a short signed displacement. The block works out the effective byte address. The low address bits and the mode then select the byte lanes to write. The block issues exactly one word-aligned write beat with byte enables, and the bytes of the value stay in their own lanes.

In end mode at a word-aligned address no byte is written. The block still issues one beat with all enables clear and a probe flag raised, so that the memory side can run its write-permission check. When the modify flag is set, the block then returns an updated base value through a one-cycle writeback strobe. That value is the base plus the displacement, rounded down to a word boundary.

Both data interfaces use valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the request has fully retired, including its writeback. The memory beat holds `mem_valid` and all of its fields steady until `mem_ready` is seen high on a rising edge. The writeback strobe has no back-pressure.

Top module: `partial_store_unit`

## Requirements
- R1: After reset `mem_valid` and `wb_valid` are low and `req_ready` is high.
- R2: Begin mode (`req_end`=0) writes byte numbers `off` through 3, where byte 0 is `mem_data[31:24]` with enable `mem_be[3]` and byte 3 is `mem_data[7:0]` with enable `mem_be[0]`. For offsets 0, 1, 2 and 3, `mem_be` is 1111, 0111, 0011 and 0001. Each enabled lane carries the same lane of the value, and disabled lanes are zero.
- R3: End mode (`req_end`=1) at offset 1, 2 or 3 writes byte numbers 0 through `off`-1, so `mem_be` is 1000, 1100 or 1110. The lanes are the upper lanes of the value, and disabled lanes are zero.
- R4: End mode at offset 0 issues one beat with `mem_be`=0000, `mem_data`=0 and `mem_probe`=1. Every other beat has `mem_probe`=0.
- R5: Each accepted request produces exactly one memory beat. A three-byte write is a single beat, never split.
- R6: The effective address is the base alone when `req_modify`=1 or the decoded displacement is zero. Otherwise it is the base plus the displacement. `mem_addr` is the effective address with its two low bits cleared, and `off` is its two low bits.
- R7: The 5-bit `req_disp` field decodes with bit 0 as the sign and bits 4:1 as the magnitude bits: value = bits[4:1] − 16·bit0. The range is −16 to +15, and the field 00001 means −16, not zero.
- R8: With `req_modify`=1, `wb_valid` pulses for one cycle, one cycle after the beat is accepted. `wb_value` is (base + displacement) with bits 1:0 cleared. With `req_modify`=0 no writeback pulse occurs.
- R9: While `mem_valid` is high and `mem_ready` low, the beat's fields stay stable. `req_ready` stays low from acceptance until the request retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_end | input | 1 | 0 = begin mode, 1 = end mode |
| req_base | input | 32 | Base register value |
| req_value | input | 32 | Register value to store |
| req_modify | input | 1 | Update the base register |
| req_disp | input | 5 | Displacement field, sign in bit 0 |
| mem_valid | output | 1 | Write beat present |
| mem_ready | input | 1 | Memory takes the beat |
| mem_addr | output | 32 | Word-aligned address |
| mem_be | output | 4 | Byte enables, bit 3 = byte 0 |
| mem_data | output | 32 | Lane-placed write data |
| mem_probe | output | 1 | Permission probe only, no bytes |
| wb_valid | output | 1 | One-cycle base writeback strobe |
| wb_value | output | 32 | New base value |

## Verification
The bench covers every offset in both modes. If the mode were inverted or the lane order reversed, the byte enables would be wrong at each offset, and unmasked lanes would show up as nonzero data. End mode at offset 0 is the corner that must produce a probe beat with no enables: a design that dropped that beat would leave an expected item unmatched, and one that treated it as a full word would show all four enables. Two displacement cases target the sign bit sitting in the low position. With the field 00001, a design reading it as +1 or as zero would pick the wrong address. With a non-modify store whose displacement moves the address across a word boundary, a design that always used the base would report the wrong word and offset. The bench also puts random stalls on `mem_ready` to expose beats that change while stalled, as well as writebacks that are missing, repeated, or raised without the modify flag.

// File: rtl/pstore_pkg.sv
package pstore_pkg;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_SEND = 2'd1,
    PS_WB   = 2'd2
  } pstore_state_e;

  typedef enum logic {
    MODE_BEGIN = 1'b0,
    MODE_END   = 1'b1
  } pstore_mode_e;

endpackage

// File: rtl/pstore_addr_gen.sv
module pstore_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 5,
  parameter int OFF_W  = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp_field,
  input  logic              modify,
  output logic [ADDR_W-1:0] word_addr,
  output logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] wb_value
);
  localparam int          EXT_W    = ADDR_W - DISP_W + 1;
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << OFF_W) - 1);

  logic [ADDR_W-1:0] disp_sx;
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] eff;
  logic              disp_zero;

  // Sign sits in the field's least significant bit.
  assign disp_sx   = {{EXT_W{disp_field[0]}}, disp_field[DISP_W-1:1]};
  assign disp_zero = (disp_sx == '0);
  assign sum       = base + disp_sx;
  assign eff       = (modify || disp_zero) ? base : sum;
  assign word_addr = eff & ~LOW_MASK;
  assign offset    = eff[OFF_W-1:0];
  assign wb_value  = sum & ~LOW_MASK;

  always_comb begin
    // R7
    disp_sign_chk: assert (!(disp_field[0] && disp_zero))
      else $error("negative displacement decoded as zero");
  end
endmodule

// File: rtl/pstore_lane_map.sv
module pstore_lane_map #(
  parameter int NBYTES = 4,
  parameter int OFF_W  = 2
) (
  input  logic                  end_mode,
  input  logic [OFF_W-1:0]      offset,
  input  logic [NBYTES*8-1:0]   value,
  output logic [NBYTES-1:0]     be,
  output logic [NBYTES*8-1:0]   data,
  output logic                  probe
);
  localparam int CMP_W = OFF_W + 1;

  logic [CMP_W-1:0] off_ext;
  assign off_ext = {1'b0, offset};

  // Lane j holds byte number NBYTES-1-j (big-endian numbering).
  for (genvar j = 0; j < NBYTES; j++) begin : g_lane
    localparam int BYTE_NUM = NBYTES - 1 - j;
    logic sel;
    assign sel = end_mode ? (CMP_W'(BYTE_NUM) < off_ext)
                          : (CMP_W'(BYTE_NUM) >= off_ext);
    assign be[j]          = sel;
    assign data[j*8 +: 8] = sel ? value[j*8 +: 8] : 8'h00;
  end

  assign probe = end_mode && (offset == '0);

  always_comb begin
    // R2
    begin_last_lane_chk: assert (end_mode || be[0])
      else $error("begin mode must always write the last byte");
    // R4
    probe_empty_chk: assert (!probe || (be == '0 && data == '0))
      else $error("probe beat carries enabled bytes");
    // R3
    end_first_lane_chk: assert (!end_mode || probe || be[NBYTES-1])
      else $error("end mode must write byte 0");
  end
endmodule

// File: rtl/pstore_ctrl.sv
module pstore_ctrl
  import pstore_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NBYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_modify,
  input  logic [ADDR_W-1:0]     in_addr,
  input  logic [NBYTES-1:0]     in_be,
  input  logic [NBYTES*8-1:0]   in_data,
  input  logic                  in_probe,
  input  logic [ADDR_W-1:0]     in_wb,
  output logic                  mem_valid,
  input  logic                  mem_ready,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [NBYTES-1:0]     mem_be,
  output logic [NBYTES*8-1:0]   mem_data,
  output logic                  mem_probe,
  output logic                  wb_valid,
  output logic [ADDR_W-1:0]     wb_value
);
  pstore_state_e state_q;
  logic          modify_q;
  logic          take_req;
  logic          take_mem;

  assign req_ready = (state_q == PS_IDLE);
  assign take_req  = req_valid && req_ready;
  assign mem_valid = (state_q == PS_SEND);
  assign take_mem  = mem_valid && mem_ready;
  assign wb_valid  = (state_q == PS_WB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= PS_IDLE;
      modify_q <= 1'b0;
      mem_addr <= '0;
      mem_be   <= '0;
      mem_data <= '0;
      mem_probe <= 1'b0;
      wb_value <= '0;
    end else begin
      case (state_q)
        PS_IDLE: if (take_req) begin
          state_q   <= PS_SEND;
          modify_q  <= req_modify;
          mem_addr  <= in_addr;
          mem_be    <= in_be;
          mem_data  <= in_data;
          mem_probe <= in_probe;
          wb_value  <= in_wb;
        end
        PS_SEND: if (take_mem) state_q <= modify_q ? PS_WB : PS_IDLE;
        PS_WB:   state_q <= PS_IDLE;
        default: state_q <= PS_IDLE;
      endcase
    end
  end

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
      $stable(mem_be) && $stable(mem_data) && $stable(mem_probe)));

  // R5
  req_to_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_req |=> mem_valid);

  // R8
  wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);

  // R8
  wb_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> $past(take_mem));

  // R9
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid || wb_valid) |-> !req_ready);

  // R6
  aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[1:0] == 2'b00));
endmodule

// File: rtl/partial_store_unit.sv
module partial_store_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DISP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_end,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [DATA_W-1:0] req_value,
  input  logic              req_modify,
  input  logic [DISP_W-1:0] req_disp,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0] mem_data,
  output logic              mem_probe,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_value
);
  localparam int NBYTES = DATA_W / 8;
  localparam int OFF_W  = $clog2(NBYTES);

  logic [ADDR_W-1:0] word_addr;
  logic [OFF_W-1:0]  offset;
  logic [ADDR_W-1:0] next_base;
  logic [NBYTES-1:0] lane_be;
  logic [DATA_W-1:0] lane_data;
  logic              lane_probe;

  pstore_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .OFF_W(OFF_W)) u_addr (
    .base       (req_base),
    .disp_field (req_disp),
    .modify     (req_modify),
    .word_addr  (word_addr),
    .offset     (offset),
    .wb_value   (next_base)
  );

  pstore_lane_map #(.NBYTES(NBYTES), .OFF_W(OFF_W)) u_lanes (
    .end_mode (req_end),
    .offset   (offset),
    .value    (req_value),
    .be       (lane_be),
    .data     (lane_data),
    .probe    (lane_probe)
  );

  pstore_ctrl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_modify (req_modify),
    .in_addr    (word_addr),
    .in_be      (lane_be),
    .in_data    (lane_data),
    .in_probe   (lane_probe),
    .in_wb      (next_base),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .mem_data   (mem_data),
    .mem_probe  (mem_probe),
    .wb_valid   (wb_valid),
    .wb_value   (wb_value)
  );
endmodule

// File: tb/partial_store_unit_bench.sv
module partial_store_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_end = 1'b0;
  logic [31:0] req_base = '0;
  logic [31:0] req_value = '0;
  logic        req_modify = 1'b0;
  logic [4:0]  req_disp = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_data;
  logic        mem_probe;
  logic        wb_valid;
  logic [31:0] wb_value;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [68:0] exp_beat_q[$];  // {probe, be, addr, data}
  string       exp_tag_q[$];
  logic [31:0] exp_wb_q[$];

  always #4 clk = ~clk;

  partial_store_unit u_partial_store_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_end(req_end), .req_base(req_base), .req_value(req_value),
    .req_modify(req_modify), .req_disp(req_disp), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_data(mem_data), .mem_probe(mem_probe), .wb_valid(wb_valid),
    .wb_value(wb_value)
  );

  // Memory back-pressure pattern, changed just after each rising edge.
  logic [7:0] lfsr = 8'hA5;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready = lfsr[0] | lfsr[2];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [68:0] act, input logic [68:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic e, input logic [31:0] base,
                      input logic [31:0] val, input logic m,
                      input logic [4:0] f, input string tag);
    logic [31:0] disp, eff, sum, dmask;
    logic [3:0]  be;
    logic [1:0]  off;
    disp = {{28{f[0]}}, f[4:1]};
    sum  = base + disp;
    eff  = (m || disp == 0) ? base : sum;
    off  = eff[1:0];
    if (!e) begin
      case (off)
        2'd0: be = 4'b1111;
        2'd1: be = 4'b0111;
        2'd2: be = 4'b0011;
        default: be = 4'b0001;
      endcase
    end else begin
      case (off)
        2'd0: be = 4'b0000;
        2'd1: be = 4'b1000;
        2'd2: be = 4'b1100;
        default: be = 4'b1110;
      endcase
    end
    dmask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    exp_beat_q.push_back({(e && off == 2'd0), be, eff & 32'hFFFF_FFFC, val & dmask});
    exp_tag_q.push_back(tag);
    if (m) exp_wb_q.push_back(sum & 32'hFFFF_FFFC);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_end = e; req_base = base; req_value = val;
    req_modify = m; req_disp = f;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  logic        stall_prev = 1'b0;
  logic [68:0] beat_prev = '0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [68:0] cur;
      cur = {mem_probe, mem_be, mem_addr, mem_data};
      if (stall_prev)
        check(mem_valid && cur == beat_prev, "R9", "beat changed while stalled", cur, beat_prev);
      if (mem_valid || wb_valid)
        check(!req_ready, "R9", "req_ready while busy", 69'(req_ready), 69'(0));
      if (mem_valid && mem_ready) begin
        if (exp_beat_q.size() == 0)
          check(1'b0, "R5", "unexpected beat", cur, 69'(0));
        else begin
          logic [68:0] exp;
          string tag;
          exp = exp_beat_q.pop_front();
          tag = exp_tag_q.pop_front();
          check(cur == exp, tag, "beat {probe,be,addr,data}", cur, exp);
        end
      end
      if (wb_valid) begin
        if (exp_wb_q.size() == 0)
          check(1'b0, "R8", "unexpected writeback", 69'(wb_value), 69'(0));
        else begin
          logic [31:0] w;
          w = exp_wb_q.pop_front();
          check(wb_value == w, "R8", "writeback value", 69'(wb_value), 69'(w));
        end
      end
      stall_prev = mem_valid && !mem_ready;
      beat_prev  = cur;
    end
  end

  // Watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!mem_valid && !wb_valid && req_ready, "R1", "reset outputs",
          69'({mem_valid, wb_valid, req_ready}), 69'(3'b001));
    rst_n = 1'b1;
    @(negedge clk);
    // R2 begin mode, every offset
    send(1'b0, 32'h0000_1000, 32'hA1B2_C3D4, 1'b0, 5'b00000, "R2");
    send(1'b0, 32'h0000_1001, 32'hA1B2_C3D4, 1'b0, 5'b00000, "R5");
    send(1'b0, 32'h0000_1002, 32'h1122_3344, 1'b0, 5'b00000, "R2");
    send(1'b0, 32'h0000_1003, 32'h5566_7788, 1'b0, 5'b00000, "R2");
    // R3 end mode, nonzero offsets
    send(1'b1, 32'h0000_2001, 32'hDEAD_BEEF, 1'b0, 5'b00000, "R3");
    send(1'b1, 32'h0000_2002, 32'hCAFE_F00D, 1'b0, 5'b00000, "R3");
    send(1'b1, 32'h0000_2003, 32'h0BAD_C0DE, 1'b0, 5'b00000, "R5");
    // R4 end mode at offset zero: probe only
    send(1'b1, 32'h0000_2000, 32'hFFFF_FFFF, 1'b0, 5'b00000, "R4");
    // R6/R7 displacement moves the address when not modifying
    send(1'b0, 32'h0000_3000, 32'h1234_5678, 1'b0, 5'b00110, "R6");
    send(1'b1, 32'h0000_3010, 32'h8765_4321, 1'b0, 5'b00111, "R7");
    send(1'b0, 32'h0000_6001, 32'h0F0F_0F0F, 1'b0, 5'b00001, "R7");
    // R8 modify: base address used, writeback rounded down
    send(1'b0, 32'h0000_4001, 32'hAAAA_5555, 1'b1, 5'b00110, "R8");
    send(1'b1, 32'h0000_4010, 32'h1357_9BDF, 1'b1, 5'b00111, "R8");
    send(1'b0, 32'h0000_5002, 32'h2468_ACE0, 1'b1, 5'b00000, "R8");
    send(1'b1, 32'h0000_7003, 32'h7777_8888, 1'b1, 5'b11110, "R8");
    // Back-to-back mixture
    for (int i = 0; i < 8; i++)
      send(i[0], 32'h0000_8000 + 32'(i * 5), 32'h0102_0304 * 32'(i + 1),
           i[1], 5'(i * 7), "R6");
    while (exp_beat_q.size() != 0 || exp_wb_q.size() != 0 || !req_ready)
      @(negedge clk);
    repeat (4) @(negedge clk);
    check(exp_beat_q.size() == 0 && exp_wb_q.size() == 0, "R5", "leftover items",
          69'(exp_beat_q.size() + exp_wb_q.size()), 69'(0));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule